// File: doc/BRIEF.md
# Multi-destination interrupt aggregator

This block gathers 86 active-high level interrupt sources into one register-mapped controller. Every source that is high on a clock edge latches a pending bit that stays set until software acknowledges it. A per-source enable gates the pending bit. Each of nine destination outputs then picks, through its own routing bitmap, which enabled pending sources it reports. Sources are taken as already synchronous to the block clock.

Software uses a plain 32-bit register port. The port carries a valid strobe, a write flag, a word address and write data, and every access takes one cycle. Sources sit in three banks of 32: source `s` is bank `s/32`, bit `s%32`. Enables are never written directly. Software changes them only through a write-one-to-set alias and a write-one-to-clear alias. For every destination and bank, a read-only identity word shows which sources currently drive that destination. An interrupt handler reads its destination's identity words, services the sources, and acknowledges them in the pending registers.

Top module: `irqAggTop`

## Requirements
- R1: After reset every pending, enable and routing bit is zero, `dstIrq` is all zeros and `busRdata` is zero.
- R2: A pending bit is set on every clock edge where its source is high. If an acknowledge write to that bit lands on the same edge, the set wins.
- R3: The pending words sit at byte offsets 0x30, 0x34 and 0x38 (word address = byte offset / 4), one per bank. A write clears each bit that is one in the data and leaves each bit that is zero untouched.
- R4: The enable words read back at 0x48, 0x4C and 0x50. Writing to the set aliases at 0x60, 0x64 and 0x68 sets each enable bit that is one in the data. Zero bits have no effect. Reads of any set or clear alias return the bank's enable word.
- R5: Writing to the clear aliases at 0x54, 0x58 and 0x5C clears each enable bit that is one in the data. Zero bits have no effect. A direct write to an enable word at 0x48 to 0x50 changes nothing.
- R6: Destination n (0 to 8) has one read/write routing word per bank, at 0x78+4n, 0x9C+4n and 0xC0+4n.
- R7: Destination n has one read-only identity word per bank, at 0xE4+4n, 0x108+4n and 0x12C+4n. It reads as pending AND enable AND routing. Writes to it are ignored.
- R8: `dstIrq[n]` is a register that holds the OR of destination n's identity words as they stood one edge earlier. It rises one cycle after a routed, enabled bit becomes pending. It falls one cycle after the last such bit is cleared.
- R9: Bits 22 to 31 of every bank-2 word stand for no source. They read as zero and ignore writes.
- R10: A byte offset outside the ranges above reads as zero, and a write to it changes no state.
- R11: `busRdata` loads on the edge that ends a read cycle and holds its value in every cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevel | input | 86 | Active-high level interrupt sources |
| busValid | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Word address (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| dstIrq | output | 9 | Level interrupt for each destination |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands on the same edge as a still-high source. It must be paired with a destination output that falls exactly one cycle after its last routed bit goes away. The bench holds chosen sources high across acknowledge writes. It routes single sources, including the top source 85, to several destinations at once. It then drops sources and clears enables one at a time, so each output's falling edge is tested against a cycle-accurate model. A long stretch of random accesses over all the live offsets covers the rest.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  parameter int NUM_SRC = 86;
  parameter int NUM_DST = 9;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 8;

  localparam int NUM_BANK = (NUM_SRC + DATA_W - 1) / DATA_W;
  localparam int PAD_W    = NUM_BANK * DATA_W;
  localparam int BANK_IW  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
  localparam int DST_IW   = (NUM_DST > 1) ? $clog2(NUM_DST) : 1;

  // word-address bases of each register group
  localparam int PEND_BASE  = 12;
  localparam int ENA_BASE   = 18;
  localparam int CLR_BASE   = 21;
  localparam int SET_BASE   = 24;
  localparam int ROUTE_BASE = 30;
  localparam int IDENT_BASE = ROUTE_BASE + NUM_BANK * NUM_DST;

  typedef enum logic [2:0] {
    RD_NONE, RD_PEND, RD_ENA, RD_ROUTE, RD_IDENT
  } rdKind_e;

  typedef struct packed {
    logic [NUM_BANK-1:0]         ackBank;
    logic [NUM_BANK-1:0]         setBank;
    logic [NUM_BANK-1:0]         clrBank;
    logic [NUM_DST*NUM_BANK-1:0] routeWr;
    logic                        rdEn;
    rdKind_e                     rdKind;
    logic [BANK_IW-1:0]          rdBank;
    logic [DST_IW-1:0]           rdDst;
  } strobe_t;
endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe
);
  logic wrEn;
  assign wrEn = busValid & busWrite;

  always_comb begin
    strobe      = '0;
    strobe.rdEn = busValid & ~busWrite;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (busAddr == ADDR_W'(PEND_BASE + b)) begin
        strobe.ackBank[b] = wrEn;
        strobe.rdKind     = RD_PEND;
        strobe.rdBank     = BANK_IW'(b);
      end
      if (busAddr == ADDR_W'(ENA_BASE + b)) begin
        strobe.rdKind = RD_ENA;
        strobe.rdBank = BANK_IW'(b);
      end
      if (busAddr == ADDR_W'(CLR_BASE + b)) begin
        strobe.clrBank[b] = wrEn;
        strobe.rdKind     = RD_ENA;
        strobe.rdBank     = BANK_IW'(b);
      end
      if (busAddr == ADDR_W'(SET_BASE + b)) begin
        strobe.setBank[b] = wrEn;
        strobe.rdKind     = RD_ENA;
        strobe.rdBank     = BANK_IW'(b);
      end
      for (int d = 0; d < NUM_DST; d++) begin
        if (busAddr == ADDR_W'(ROUTE_BASE + b * NUM_DST + d)) begin
          strobe.routeWr[b*NUM_DST+d] = wrEn;
          strobe.rdKind = RD_ROUTE;
          strobe.rdBank = BANK_IW'(b);
          strobe.rdDst  = DST_IW'(d);
        end
        if (busAddr == ADDR_W'(IDENT_BASE + b * NUM_DST + d)) begin
          strobe.rdKind = RD_IDENT;
          strobe.rdBank = BANK_IW'(b);
          strobe.rdDst  = DST_IW'(d);
        end
      end
    end
  end
endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [DATA_W-1:0]  busWdata,
  input  strobe_t            strobe,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_DST-1:0] dstIrq
);
  localparam logic [PAD_W-1:0] LIVE_MASK = (PAD_W'(1) << NUM_SRC) - PAD_W'(1);

  logic [PAD_W-1:0] pendQ, enaQ, pendD, enaD;
  logic [PAD_W-1:0] ackVec, setVec, clrVec, srcPad;
  logic [NUM_DST-1:0][PAD_W-1:0] routeAll, identAll;
  logic [NUM_DST-1:0] dstQ;
  logic [DATA_W-1:0] rdMux, rdataQ;

  assign srcPad = PAD_W'(srcLevel);

  always_comb begin
    ackVec = '0;
    setVec = '0;
    clrVec = '0;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (strobe.ackBank[b]) ackVec[b*DATA_W +: DATA_W] = busWdata;
      if (strobe.setBank[b]) setVec[b*DATA_W +: DATA_W] = busWdata;
      if (strobe.clrBank[b]) clrVec[b*DATA_W +: DATA_W] = busWdata;
    end
    pendD = ((pendQ & ~ackVec) | srcPad) & LIVE_MASK;
    enaD  = ((enaQ & ~clrVec) | setVec) & LIVE_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      enaQ  <= '0;
    end else begin
      pendQ <= pendD;
      enaQ  <= enaD;
    end
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    logic [PAD_W-1:0] routeRow;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        routeRow <= '0;
      end else begin
        for (int b = 0; b < NUM_BANK; b++) begin
          if (strobe.routeWr[b*NUM_DST+d])
            routeRow[b*DATA_W +: DATA_W] <= busWdata & LIVE_MASK[b*DATA_W +: DATA_W];
        end
      end
    end
    assign routeAll[d] = routeRow;
    assign identAll[d] = pendQ & enaQ & routeRow;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dstQ[d] <= 1'b0;
      else       dstQ[d] <= |(pendQ & enaQ & routeRow);
    end
  end

  always_comb begin
    int base;
    base  = int'(strobe.rdBank) * DATA_W;
    rdMux = '0;
    unique case (strobe.rdKind)
      RD_PEND:  rdMux = pendQ[base +: DATA_W];
      RD_ENA:   rdMux = enaQ[base +: DATA_W];
      RD_ROUTE: rdMux = routeAll[strobe.rdDst][base +: DATA_W];
      RD_IDENT: rdMux = identAll[strobe.rdDst][base +: DATA_W];
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdataQ <= '0;
    else if (strobe.rdEn) rdataQ <= rdMux;
  end

  assign busRdata = rdataQ;
  assign dstIrq   = dstQ;
endmodule

// File: rtl/irqAggTop.sv
module irqAggTop
  import irqAggPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_DST-1:0] dstIrq
);
  strobe_t strobe;

  irqAggCtrl u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  irqAggDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcLevel (srcLevel),
    .busWdata (busWdata),
    .strobe   (strobe),
    .busRdata (busRdata),
    .dstIrq   (dstIrq)
  );
endmodule

// File: rtl/irqAggChecker.sv
module irqAggChecker
  import irqAggPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input strobe_t           strobe
);
  logic isRead;
  assign isRead = busValid & ~busWrite;

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> $stable(busRdata));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && busAddr == '0) |=> (busRdata == '0));

  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.ackBank, strobe.setBank, strobe.clrBank, strobe.routeWr}) <= 1);

  assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |->
      ({strobe.ackBank, strobe.setBank, strobe.clrBank, strobe.routeWr} == '0));

  if (NUM_SRC < PAD_W) begin : g_pad
    localparam int LIVE_TOP = NUM_SRC - (NUM_BANK - 1) * DATA_W;
    assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
      (isRead && busAddr == ADDR_W'(PEND_BASE + NUM_BANK - 1))
        |=> (busRdata[DATA_W-1:LIVE_TOP] == '0));
  end
endmodule

bind irqAggTop irqAggChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .strobe   (strobe)
);

// File: tb/irqAggTop_tb.sv
module irqAggTop_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 86;
  localparam int ND = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [85:0] srcLevel = '0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [8:0]  dstIrq;

  irqAggTop u_dut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .dstIrq(dstIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state
  bit [95:0] mPend, mEna;
  bit [95:0] mRoute [ND];
  bit [8:0]  mDst;
  bit [31:0] mRdata;
  int compared = 0, mismatched = 0;
  string curReq = "R1";
  bit finished = 0;

  function automatic bit [95:0] liveMask();
    bit [95:0] m = '0;
    for (int i = 0; i < NS; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic bit [31:0] modelRead(int off);
    int k;
    if (off >= 'h30 && off <= 'h38) return mPend[(off-'h30)/4*32 +: 32];
    if (off >= 'h48 && off <= 'h68) return mEna[((off-'h48)/4)%3*32 +: 32];
    if (off >= 'h78 && off < 'hE4) begin
      k = (off - 'h78) / 4;
      return mRoute[k%9][(k/9)*32 +: 32];
    end
    if (off >= 'hE4 && off < 'h150) begin
      k = (off - 'hE4) / 4;
      return (mPend & mEna & mRoute[k%9]) >> ((k/9)*32);
    end
    return 32'h0;
  endfunction

  // one bus cycle: drive, advance the model, compare after the edge
  task automatic step(bit v, bit w, int off, bit [31:0] data);
    bit [95:0] nPend, nEna, src;
    int k, b;
    busValid = v; busWrite = w; busAddr = 8'(off / 4); busWdata = data;
    src = 96'(srcLevel);
    for (int d = 0; d < ND; d++) mDst[d] = |(mPend & mEna & mRoute[d]);
    if (v && !w) mRdata = modelRead(off);
    nPend = mPend; nEna = mEna;
    if (v && w) begin
      if (off >= 'h30 && off <= 'h38) begin
        b = (off - 'h30) / 4;
        nPend[b*32 +: 32] = mPend[b*32 +: 32] & ~data;
      end else if (off >= 'h54 && off <= 'h5C) begin
        b = (off - 'h54) / 4;
        nEna[b*32 +: 32] = mEna[b*32 +: 32] & ~data;
      end else if (off >= 'h60 && off <= 'h68) begin
        b = (off - 'h60) / 4;
        nEna[b*32 +: 32] = mEna[b*32 +: 32] | data;
      end else if (off >= 'h78 && off < 'hE4) begin
        k = (off - 'h78) / 4;
        mRoute[k%9][(k/9)*32 +: 32] = data;
        mRoute[k%9] &= liveMask();
      end
    end
    mPend = (nPend | src) & liveMask();
    mEna  = nEna & liveMask();
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0;
    compared++;
    if (dstIrq !== mDst) begin
      mismatched++;
      $display("FAIL %s: dstIrq act=%h exp=%h", curReq, dstIrq, mDst);
    end
    compared++;
    if (busRdata !== mRdata) begin
      mismatched++;
      $display("FAIL %s: busRdata act=%h exp=%h (offset %h)", curReq, busRdata, mRdata, off);
    end
  endtask

  task automatic wr(int off, bit [31:0] d); step(1, 1, off, d); endtask
  task automatic rd(int off);               step(1, 0, off, 32'h0); endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    compared++;
    if (dstIrq !== 9'h0 || busRdata !== 32'h0) begin
      mismatched++;
      $display("FAIL R1: reset outputs act=%h/%h exp=0/0", dstIrq, busRdata);
    end
    rstN = 1'b1;
    rd('h30); rd('h48); rd('h78); rd('h140);

    curReq = "R10";
    rd('h00); rd('h70); rd('h150); rd('h3C);
    wr('h40, 32'hFFFF_FFFF); wr('h74, 32'hFFFF_FFFF); rd('h40); rd('h48);

    curReq = "R4";
    wr('h60, 32'hA5A5_0F0F); rd('h48); rd('h60); rd('h54);
    wr('h60, 32'h0000_0000); rd('h48);
    wr('h48, 32'hFFFF_FFFF); rd('h48);   // R5: direct write has no effect

    curReq = "R5";
    wr('h54, 32'h0000_0F00); rd('h48);
    wr('h54, 32'h0000_0000); rd('h4C);
    wr('h54, 32'hFFFF_FFFF); rd('h48);

    curReq = "R6";
    for (int d = 0; d < ND; d++) wr('h78 + 4*d, 32'h1 << d);
    for (int d = 0; d < ND; d++) rd('h78 + 4*d);
    wr('hC0 + 4*8, 32'h0020_0000); rd('hC0 + 4*8);
    wr('h9C + 4*3, 32'h8000_0001); rd('h9C + 4*3);

    curReq = "R2";
    srcLevel[0] = 1'b1; idle(1); srcLevel[0] = 1'b0;
    rd('h30);
    srcLevel[3] = 1'b1;
    wr('h30, 32'h0000_0009); rd('h30);   // set wins on bit 3, bit 0 clears
    srcLevel[3] = 1'b0;

    curReq = "R3";
    wr('h30, 32'h0000_0000); rd('h30);
    wr('h30, 32'hFFFF_FFFF); rd('h30);

    curReq = "R8";
    wr('h60, 32'h0000_01FF);             // enable sources 0..8
    srcLevel[2] = 1'b1; idle(1); srcLevel[2] = 1'b0;
    idle(2);
    wr('h54, 32'h0000_0004); idle(2);    // drop enable: dst 2 falls
    wr('h60, 32'h0000_0004); idle(2);
    wr('h30, 32'h0000_0004); idle(2);    // acknowledge: dst 2 falls
    wr('h68, 32'h0020_0000);             // enable source 85
    wr('hC0 + 4*0, 32'h0020_0000);       // also route it to dst 0
    srcLevel[85] = 1'b1; idle(3);
    wr('h38, 32'h0020_0000); idle(1);    // still high: stays pending
    srcLevel[85] = 1'b0;
    wr('h38, 32'h0020_0000); idle(2);

    curReq = "R7";
    srcLevel[4] = 1'b1; srcLevel[63] = 1'b1; idle(1);
    wr('h64, 32'h8000_0000);
    rd('hE4 + 4*4); rd('h108 + 4*3); rd('hE4 + 4*0);
    wr('hE4 + 4*4, 32'h0); rd('hE4 + 4*4);
    srcLevel[4] = 1'b0; srcLevel[63] = 1'b0;

    curReq = "R9";
    wr('h68, 32'hFFFF_FFFF); rd('h50); rd('h68);
    wr('hC0 + 4*5, 32'hFFFF_FFFF); rd('hC0 + 4*5);
    srcLevel[85:64] = '1; idle(1); srcLevel[85:64] = '0;
    rd('h38); rd('h12C + 4*5);
    wr('h38, 32'hFFFF_FFFF); rd('h38);

    curReq = "R11";
    rd('h50); idle(4); wr('h54, 32'hFFFF_FFFF); idle(2);

    curReq = "R8";
    for (int i = 0; i < 3000; i++) begin
      int sel, off;
      srcLevel = {22'($urandom), $urandom, $urandom} & {$urandom, $urandom, $urandom};
      sel = $urandom_range(0, 5);
      case (sel)
        0: off = 'h30 + 4 * $urandom_range(0, 2);
        1: off = 'h54 + 4 * $urandom_range(0, 5);
        2: off = 'h78 + 4 * $urandom_range(0, 26);
        3: off = 'hE4 + 4 * $urandom_range(0, 26);
        4: off = 'h48 + 4 * $urandom_range(0, 2);
        default: off = 4 * $urandom_range(0, 90);
      endcase
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, off, $urandom);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule